// File: doc/BRIEF.md
# Packed FP4 Pair to Half-Precision Converter

This block widens two 4-bit minifloats packed into one byte into two IEEE 754 half-precision (FP16) numbers. Each 4-bit element has a sign bit at the top, a 2-bit exponent field with a bias of 1, and a single mantissa bit at the bottom. An exponent field of zero marks the subnormal and zero codes. Every one of the sixteen codes has an exact FP16 encoding, so no rounding, saturation or special-value logic is needed.

A producer presents a byte together with a valid strobe. One clock later the block presents a 32-bit word with a valid flag. The element in the low nibble fills the lower FP16 lane and the element in the high nibble fills the upper lane. A small two-state output controller, with the states `OUT_IDLE` and `OUT_LIVE`, drives the valid flag. It takes the transition `LOAD` to `OUT_LIVE` on any cycle with a strobe, and the transition `DRAIN` back to `OUT_IDLE` on any cycle without one. The data register loads only on a strobe, so the word stays unchanged between results.

Top module: `fp4x2_to_half2`

## Requirements
- R1: While reset is asserted (active-low `rst_n`) and after its release, with no strobe yet, `res_valid` is 0 and `res_word` is 0x00000000.
- R2: An element whose exponent field (bits [2:1]) is 0 converts to 0x0000 when its mantissa bit is 0 and to 0x3800 (0.5) when it is 1, with the sign bit applied as in R4.
- R3: An element whose exponent field e is 1, 2 or 3 converts to 2^(e-1)*(1+m/2). The magnitudes for codes 2 to 7 are 0x3C00, 0x3E00, 0x4000, 0x4200, 0x4400 and 0x4600.
- R4: FP16 bit 15 of each lane copies bit 3 of its element, and this includes negative zero: code 0x8 converts to 0x8000.
- R5: Input bits [3:0] give lane bits [15:0] of `res_word`, and input bits [7:4] give lane bits [31:16].
- R6: `res_valid` is high in exactly the cycle after a cycle where `pk_valid` was high, and it then carries the result for that byte.
- R7: When `pk_valid` is low, `res_word` holds its previous value in the next cycle.
- R8: Every result is exact. The low 9 mantissa bits of each lane are 0, and each lane's exponent field is 0 or lies in 14 to 17.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pk_valid | input | 1 | Strobe: `pk_byte` holds a pair to convert |
| pk_byte | input | 8 | Two packed 4-bit elements, even element in the low nibble |
| res_valid | output | 1 | High for one cycle per converted byte |
| res_word | output | 32 | Two FP16 lanes, even element in [15:0] |

## Verification
On every cycle the assertions check the valid timing and the hold behaviour. They also check, from the byte registered one cycle earlier, that each lane's sign bit matches its element, and that each lane's exponent and low mantissa bits fall inside the exact-conversion range. Only the bench scenarios can show the exact value of each of the sixteen codes, the nibble-to-lane order across all 256 bytes, negative zero, and the reset contents. The scenarios mix back-to-back strobes with gaps so that both controller transitions and the hold path are exercised.

// File: rtl/fp4cvt_pkg.sv
package fp4cvt_pkg;

    localparam int unsigned ELEM_W     = 4;
    localparam int unsigned ELEM_EXP_W = 2;
    localparam int unsigned ELEM_BIAS  = 1;
    localparam int unsigned HALF_W     = 16;
    localparam int unsigned HALF_EXP_W = 5;
    localparam int unsigned HALF_MAN_W = 10;
    localparam int unsigned HALF_BIAS  = 15;
    localparam int unsigned LANES      = 2;

    typedef struct packed {
        logic                  sgn;
        logic [ELEM_EXP_W-1:0] exp;
        logic                  man;
    } elem_t;

    typedef enum logic {
        OUT_IDLE = 1'b0,
        OUT_LIVE = 1'b1
    } out_state_t;

endpackage

// File: rtl/e2m1_lane_decode.sv
module e2m1_lane_decode
    import fp4cvt_pkg::*;
(
    input  logic [ELEM_W-1:0] code,
    output logic [HALF_W-1:0] half
);

    localparam int unsigned REBIAS = HALF_BIAS - ELEM_BIAS;
    localparam int unsigned PAD_W  = HALF_EXP_W - ELEM_EXP_W;
    localparam int unsigned LOW_W  = HALF_MAN_W - 1;

    elem_t                  fld;
    logic [HALF_EXP_W-1:0]  h_exp;
    logic [HALF_MAN_W-1:0]  h_man;

    assign fld = elem_t'(code);

    always_comb begin
        h_exp = '0;
        h_man = '0;
        if (fld.exp == '0) begin
            // subnormal element: only 0 or 0.5, and 0.5 is normal in FP16
            if (fld.man) begin
                h_exp = HALF_EXP_W'(REBIAS);
            end
        end else begin
            h_exp = {{PAD_W{1'b0}}, fld.exp} + HALF_EXP_W'(REBIAS);
            h_man = {fld.man, {LOW_W{1'b0}}};
        end
    end

    assign half = {fld.sgn, h_exp, h_man};

endmodule

// File: rtl/fp4x2_unpack.sv
module fp4x2_unpack
    import fp4cvt_pkg::*;
(
    input  logic [LANES*ELEM_W-1:0] packed_in,
    output logic [LANES*HALF_W-1:0] halves
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        e2m1_lane_decode u_dec (
            .code (packed_in[g*ELEM_W +: ELEM_W]),
            .half (halves[g*HALF_W +: HALF_W])
        );
    end

endmodule

// File: rtl/fp4x2_to_half2.sv
module fp4x2_to_half2
    import fp4cvt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pk_valid,
    input  logic [7:0]  pk_byte,
    output logic        res_valid,
    output logic [31:0] res_word
);

    out_state_t         state_q;
    out_state_t         state_d;
    logic [31:0]        conv_w;
    logic [31:0]        word_q;

    fp4x2_unpack u_unpack (
        .packed_in (pk_byte),
        .halves    (conv_w)
    );

    // next-state: LOAD on a strobe, DRAIN otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_IDLE: state_d = pk_valid ? OUT_LIVE : OUT_IDLE;
            OUT_LIVE: state_d = pk_valid ? OUT_LIVE : OUT_IDLE;
            default:  state_d = OUT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OUT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (pk_valid) begin
            word_q <= conv_w;
        end
    end

    assign res_valid = (state_q == OUT_LIVE);
    assign res_word  = word_q;

    a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        pk_valid |=> res_valid);

    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !pk_valid |=> !res_valid);

    a_r7_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        !pk_valid |=> $stable(res_word));

    a_r4_sign_copy: assert property (@(posedge clk) disable iff (!rst_n)
        pk_valid |=> (res_word[15] == $past(pk_byte[3]))
                  && (res_word[31] == $past(pk_byte[7])));

    a_r8_exact_range: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_word[8:0] == '0) && (res_word[24:16] == '0)
            && ((res_word[14:10] == 5'd0)
                || (res_word[14:10] >= 5'd14 && res_word[14:10] <= 5'd17))
            && ((res_word[30:26] == 5'd0)
                || (res_word[30:26] >= 5'd14 && res_word[30:26] <= 5'd17)));

endmodule

// File: tb/fp4x2_to_half2_bench.sv
`timescale 1ns/1ps
module fp4x2_to_half2_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pk_valid = 1'b0;
    logic [7:0]  pk_byte = 8'h00;
    logic        res_valid;
    logic [31:0] res_word;

    int          total = 0;
    int          bad = 0;
    int          outs_seen = 0;
    int          pushed = 0;
    bit          done = 1'b0;
    bit          mon_on = 1'b0;
    logic [31:0] last_word = '0;
    logic [31:0] exp_q[$];

    always #2.5 clk = ~clk;

    fp4x2_to_half2 u_fp4x2_to_half2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .pk_valid  (pk_valid),
        .pk_byte   (pk_byte),
        .res_valid (res_valid),
        .res_word  (res_word)
    );

    // R2, R3, R4: expected FP16 encoding of one element
    function automatic logic [15:0] ref_half(input logic [3:0] c);
        logic [15:0] mag;
        case (c[2:0])
            3'd0: mag = 16'h0000;
            3'd1: mag = 16'h3800;
            3'd2: mag = 16'h3C00;
            3'd3: mag = 16'h3E00;
            3'd4: mag = 16'h4000;
            3'd5: mag = 16'h4200;
            3'd6: mag = 16'h4400;
            default: mag = 16'h4600;
        endcase
        return {c[3], mag[14:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    // R5: even element in [15:0], odd in [31:16]
    task automatic drive(input logic [7:0] b);
        @(negedge clk);
        pk_valid = 1'b1;
        pk_byte  = b;
        exp_q.push_back({ref_half(b[7:4]), ref_half(b[3:0])});
        pushed++;
    endtask

    task automatic idle(input int n, input logic [7:0] junk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pk_valid = 1'b0;
            pk_byte  = junk;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (mon_on) begin
            if (res_valid) begin
                outs_seen++;
                if (exp_q.size() == 0) begin
                    check("R6 unexpected valid", 32'h1, 32'h0);
                end else begin
                    check("R2/R3/R4/R5 lane data", res_word, exp_q.pop_front());
                end
            end else begin
                check("R7 hold while idle", res_word, last_word);
            end
            last_word = res_word;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 valid in reset", {31'b0, res_valid}, 32'h0);
        check("R1 word in reset", res_word, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", {31'b0, res_valid}, 32'h0);
        check("R1 word after reset", res_word, 32'h0);
        mon_on = 1'b1;
        // R4: negative zero in both lanes, then mixed
        drive(8'h88);
        drive(8'h08);
        drive(8'h11); // R2 subnormal
        idle(3, 8'hFF);
        // R5 asymmetric
        drive(8'h7F);
        idle(1, 8'h55);
        // exhaustive sweep with periodic gaps (R3, R6, R7)
        for (int b = 0; b < 256; b++) begin
            drive(8'(b));
            if (b % 7 == 3) idle(2, 8'(~b));
        end
        idle(4, 8'hA5);
        mon_on = 1'b0;
        check("R6 results count", 32'(outs_seen), 32'(pushed));
        check("R6 queue drained", 32'(exp_q.size()), 32'h0);
        check("R8 last word exact", res_word & 32'h01FF_01FF, 32'h0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule